// File: doc/BRIEF.md
# SuperSpeed PHY Lane Power-Up and Shutdown Sequencer

This block is a hardware state machine that takes one SuperSpeed serial PHY lane from reset to an operational state, and back down again. A start request runs a fixed choreography. It puts both the PHY-wide reset and the active-low lane reset into their asserted state. It switches on the analog supply enable together with the two power-stable flags. After a timed settle interval it lifts test power-down, and after a second interval it releases the PHY reset and then the lane reset. It then enables the receiver's separate-reference-clock (spread-spectrum independent) mode.

Once the resets are gone, the sequencer polls the lane acknowledge at a fixed interval. The PHY holds that acknowledge high while it is in reset, and its fall marks the end of reset exit. If it falls before the timeout, the block hands one register override (address 0x22, data 0x00F5) to a configuration-write engine over a valid/ready channel. If it stays high, the block raises a timeout flag. A separate disable request runs the shutdown order. All intervals come from cycle counts derived from the clock frequency parameter.

The configuration-write channel follows the usual valid/ready rules. Once `cfg_valid_o` is high, it stays high with `cfg_addr_o` and `cfg_data_o` unchanged until the engine returns `cfg_ready_i`. The transfer completes on the first rising clock edge where both are high. `cfg_ready_i` is ignored while `cfg_valid_o` is low.

Top module: `phy_pwrseq`

## Requirements
- R1: While `rst_n` is low and afterwards until a request, `phy_rst_o`=1, `lane_rst_n_o`=0 and `test_pd_o`=1. All other outputs are 0: overrides, power flags, receive mode, valid, address, data and all status flags.
- R2: On the clock edge that samples `start_i` while idle, `phy_rst_o` goes to 1 and `lane_rst_n_o` to 0, and `test_pd_o` and `busy_o` go to 1. `sris_rx_en_o`, `ready_o` and `timeout_o` are cleared on that edge. On the next edge `ana_pwr_en_o`, `pcs_pwr_stable_o` and `pma_pwr_stable_o` all go to 1 together.
- R3: `test_pd_o` falls exactly SETTLE_CYC = CLK_MHZ*SETTLE_US edges after the power flags rise.
- R4: `phy_rst_o` falls exactly SETTLE_CYC edges after `test_pd_o` falls. `lane_rst_n_o` rises one edge after that.
- R5: `sris_rx_en_o` rises one edge after `lane_rst_n_o` rises. That edge is the poll origin.
- R6: `lane_ack_i` is sampled on edges k*POLL_CYC after the poll origin, with POLL_CYC = CLK_MHZ*POLL_US and k = 1..MAX_POLLS. The first sample that reads 0 raises `cfg_valid_o` on that same edge.
- R7: If all MAX_POLLS = ceil(TIMEOUT_US/POLL_US) samples read 1, `timeout_o` rises and `done_o` pulses on the last sample edge. No write is issued and `ready_o` stays 0.
- R8: The write carries address CFG_ADDR (default 0x22) and data CFG_DATA (default 0x00F5), held stable while `cfg_ready_i` is low. On the handshake edge `cfg_valid_o` falls, `ready_o` rises and `done_o` pulses for one cycle.
- R9: A disable request while not busy acts over three edges. On the sampling edge `lane_rst_n_o` goes low and `ready_o` and `timeout_o` clear. On the next edge `phy_rst_o` goes high. On the third edge `test_pd_o` goes high and `done_o` pulses, and `busy_o` is then low.
- R10: Start and disable requests are ignored while `busy_o` is high. If both arrive together while not busy, disable wins.
- R11: Each reset's override enable goes to 1 on the first edge at which the block drives that reset, and then stays 1 until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request the power-up sequence |
| disable_i | input | 1 | Request the shutdown sequence |
| lane_ack_i | input | 1 | Lane acknowledge from the PHY, high while in reset |
| phy_rst_o | output | 1 | PHY-wide reset, active high |
| phy_rst_ovrd_o | output | 1 | Override enable for `phy_rst_o` |
| lane_rst_n_o | output | 1 | Lane reset, active low |
| lane_rst_ovrd_o | output | 1 | Override enable for `lane_rst_n_o` |
| ana_pwr_en_o | output | 1 | Analog supply enable |
| pcs_pwr_stable_o | output | 1 | Coding-sublayer power-stable flag |
| pma_pwr_stable_o | output | 1 | Analog front-end power-stable flag |
| test_pd_o | output | 1 | Test power-down, PHY unusable while high |
| sris_rx_en_o | output | 1 | Receiver independent-reference-clock mode enable |
| cfg_valid_o | output | 1 | Configuration write request valid |
| cfg_ready_i | input | 1 | Configuration engine accepts the request |
| cfg_addr_o | output | ADDR_W | Configuration register address |
| cfg_data_o | output | DATA_W | Configuration write data |
| busy_o | output | 1 | A sequence is in progress |
| ready_o | output | 1 | Power-up finished and override written |
| done_o | output | 1 | One-cycle pulse when any sequence ends |
| timeout_o | output | 1 | Acknowledge never fell within the limit |

## Verification
The assertions assume that `cfg_ready_i` is driven by a well-behaved engine, so a held request is always eventually answered. They also assume that requests are synchronous single-level inputs. The ordering and settle checks rely on the analog power flags never being cleared by anything outside the block. The bench drives every input on the falling clock edge and raises `cfg_ready_i` only after it has seen `cfg_valid_o`. It sweeps the edge on which the acknowledge falls across the whole poll window and past the timeout, and it varies the handshake delay. It also pokes requests in the middle of a sequence, which the block must ignore.

// File: rtl/phy_pwrseq_pkg.sv
package phy_pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POWER,
    ST_GAP_TPD,
    ST_GAP_RST,
    ST_REL_LANE,
    ST_SRIS,
    ST_POLL,
    ST_CFG,
    ST_READY,
    ST_TIMEOUT,
    ST_DN_PHY,
    ST_DN_TPD
  } seq_state_e;

  function automatic logic state_is_busy(input seq_state_e s);
    return !(s == ST_IDLE || s == ST_READY || s == ST_TIMEOUT);
  endfunction

endpackage

// File: rtl/phy_pwrseq_timer.sv
module phy_pwrseq_timer #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             expired_o
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/phy_pwrseq_poll.sv
module phy_pwrseq_poll #(
  parameter int POLL_CYC  = 4000,
  parameter int MAX_POLLS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);

  localparam int PC_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int NS_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PC_W-1:0] PC_RELOAD = PC_W'(POLL_CYC - 1);
  localparam logic [NS_W-1:0] NS_LAST   = NS_W'(MAX_POLLS - 1);

  logic [PC_W-1:0] gap_q;
  logic [NS_W-1:0] nsamp_q;

  assign tick_o = run_i && (gap_q == '0);
  assign last_o = tick_o && (nsamp_q == NS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      nsamp_q <= '0;
    end else if (arm_i) begin
      gap_q   <= PC_RELOAD;
      nsamp_q <= '0;
    end else if (run_i) begin
      if (gap_q == '0) begin
        gap_q   <= PC_RELOAD;
        nsamp_q <= nsamp_q + 1'b1;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/phy_pwrseq_cfgwr.sv
module phy_pwrseq_cfgwr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fire_o
);

  assign fire_o = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (launch_i && !valid_o) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else if (fire_o) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/phy_pwrseq.sv
module phy_pwrseq
  import phy_pwrseq_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int SETTLE_US  = 10,
  parameter int POLL_US    = 40,
  parameter int TIMEOUT_US = 20000,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'('h22),
  parameter logic [DATA_W-1:0] CFG_DATA = DATA_W'('h00F5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              disable_i,
  input  logic              lane_ack_i,
  output logic              phy_rst_o,
  output logic              phy_rst_ovrd_o,
  output logic              lane_rst_n_o,
  output logic              lane_rst_ovrd_o,
  output logic              ana_pwr_en_o,
  output logic              pcs_pwr_stable_o,
  output logic              pma_pwr_stable_o,
  output logic              test_pd_o,
  output logic              sris_rx_en_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int POLL_CYC   = CLK_MHZ * POLL_US;
  localparam int MAX_POLLS  = (TIMEOUT_US + POLL_US - 1) / POLL_US;
  localparam int ST_W       = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [ST_W-1:0] SETTLE_LD = ST_W'(SETTLE_CYC - 1);

  seq_state_e state_q;
  logic       tmr_load, tmr_exp;
  logic       poll_arm, poll_run, poll_tick, poll_last;
  logic       cfg_launch, cfg_fire;
  logic       req_ok;

  assign busy_o   = state_is_busy(state_q);
  assign req_ok   = !busy_o;
  assign tmr_load = (state_q == ST_POWER) ||
                    (state_q == ST_GAP_TPD && tmr_exp);
  assign poll_arm = (state_q == ST_SRIS);
  assign poll_run = (state_q == ST_POLL);
  assign cfg_launch = poll_tick && !lane_ack_i;

  phy_pwrseq_timer #(.WIDTH(ST_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (SETTLE_LD),
    .expired_o  (tmr_exp)
  );

  phy_pwrseq_poll #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (poll_arm),
    .run_i  (poll_run),
    .tick_o (poll_tick),
    .last_o (poll_last)
  );

  phy_pwrseq_cfgwr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (cfg_launch),
    .addr_i   (CFG_ADDR),
    .data_i   (CFG_DATA),
    .ready_i  (cfg_ready_i),
    .valid_o  (cfg_valid_o),
    .addr_o   (cfg_addr_o),
    .data_o   (cfg_data_o),
    .fire_o   (cfg_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q          <= ST_IDLE;
      phy_rst_o        <= 1'b1;
      phy_rst_ovrd_o   <= 1'b0;
      lane_rst_n_o     <= 1'b0;
      lane_rst_ovrd_o  <= 1'b0;
      ana_pwr_en_o     <= 1'b0;
      pcs_pwr_stable_o <= 1'b0;
      pma_pwr_stable_o <= 1'b0;
      test_pd_o        <= 1'b1;
      sris_rx_en_o     <= 1'b0;
      ready_o          <= 1'b0;
      done_o           <= 1'b0;
      timeout_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_READY, ST_TIMEOUT: begin
          if (req_ok && disable_i) begin
            lane_rst_n_o    <= 1'b0;
            lane_rst_ovrd_o <= 1'b1;
            ready_o         <= 1'b0;
            timeout_o       <= 1'b0;
            state_q         <= ST_DN_PHY;
          end else if (req_ok && start_i) begin
            phy_rst_o       <= 1'b1;
            phy_rst_ovrd_o  <= 1'b1;
            lane_rst_n_o    <= 1'b0;
            lane_rst_ovrd_o <= 1'b1;
            test_pd_o       <= 1'b1;
            sris_rx_en_o    <= 1'b0;
            ready_o         <= 1'b0;
            timeout_o       <= 1'b0;
            state_q         <= ST_POWER;
          end
        end
        ST_POWER: begin
          ana_pwr_en_o     <= 1'b1;
          pcs_pwr_stable_o <= 1'b1;
          pma_pwr_stable_o <= 1'b1;
          state_q          <= ST_GAP_TPD;
        end
        ST_GAP_TPD: begin
          if (tmr_exp) begin
            test_pd_o <= 1'b0;
            state_q   <= ST_GAP_RST;
          end
        end
        ST_GAP_RST: begin
          if (tmr_exp) begin
            phy_rst_o <= 1'b0;
            state_q   <= ST_REL_LANE;
          end
        end
        ST_REL_LANE: begin
          lane_rst_n_o <= 1'b1;
          state_q      <= ST_SRIS;
        end
        ST_SRIS: begin
          sris_rx_en_o <= 1'b1;
          state_q      <= ST_POLL;
        end
        ST_POLL: begin
          if (poll_tick) begin
            if (!lane_ack_i) begin
              state_q <= ST_CFG;
            end else if (poll_last) begin
              timeout_o <= 1'b1;
              done_o    <= 1'b1;
              state_q   <= ST_TIMEOUT;
            end
          end
        end
        ST_CFG: begin
          if (cfg_fire) begin
            ready_o <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_READY;
          end
        end
        ST_DN_PHY: begin
          phy_rst_o      <= 1'b1;
          phy_rst_ovrd_o <= 1'b1;
          state_q        <= ST_DN_TPD;
        end
        ST_DN_TPD: begin
          test_pd_o <= 1'b1;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwrseq_chk.sv
module phy_pwrseq_chk #(
  parameter int SETTLE_CYC = 1000,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phy_rst_o,
  input logic              phy_rst_ovrd_o,
  input logic              lane_rst_n_o,
  input logic              lane_rst_ovrd_o,
  input logic              ana_pwr_en_o,
  input logic              pcs_pwr_stable_o,
  input logic              pma_pwr_stable_o,
  input logic              test_pd_o,
  input logic              sris_rx_en_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic [ADDR_W-1:0] cfg_addr_o,
  input logic [DATA_W-1:0] cfg_data_o,
  input logic              busy_o,
  input logic              ready_o,
  input logic              done_o,
  input logic              timeout_o
);

  localparam int AW = $clog2(SETTLE_CYC + 2);
  logic [AW-1:0] pwr_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_age_q <= '0;
    else if (!ana_pwr_en_o) pwr_age_q <= '0;
    else if (pwr_age_q < AW'(SETTLE_CYC)) pwr_age_q <= pwr_age_q + 1'b1;
  end

  assert_tpd_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_pd_o) |-> (pwr_age_q >= AW'(SETTLE_CYC)) && pcs_pwr_stable_o && pma_pwr_stable_o);

  assert_phy_release_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rst_o) |-> (pwr_age_q >= AW'(SETTLE_CYC)) && !lane_rst_n_o && !test_pd_o);

  assert_lane_after_phy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_rst_n_o) |-> !phy_rst_o);

  assert_sris_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sris_rx_en_o) |-> lane_rst_n_o && !phy_rst_o);

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_addr_o) && $stable(cfg_data_o));

  assert_cfg_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> busy_o && !ready_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && timeout_o));

  assert_down_phy_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_o) |-> !lane_rst_n_o);

  assert_down_tpd_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_pd_o) && !busy_o |-> phy_rst_o && !lane_rst_n_o);

  assert_ovrd_phy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_o |-> phy_rst_ovrd_o);

  assert_ovrd_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lane_rst_n_o |-> lane_rst_ovrd_o);

  assert_ovrd_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst_ovrd_o |=> phy_rst_ovrd_o);

endmodule

bind phy_pwrseq phy_pwrseq_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .phy_rst_o        (phy_rst_o),
  .phy_rst_ovrd_o   (phy_rst_ovrd_o),
  .lane_rst_n_o     (lane_rst_n_o),
  .lane_rst_ovrd_o  (lane_rst_ovrd_o),
  .ana_pwr_en_o     (ana_pwr_en_o),
  .pcs_pwr_stable_o (pcs_pwr_stable_o),
  .pma_pwr_stable_o (pma_pwr_stable_o),
  .test_pd_o        (test_pd_o),
  .sris_rx_en_o     (sris_rx_en_o),
  .cfg_valid_o      (cfg_valid_o),
  .cfg_ready_i      (cfg_ready_i),
  .cfg_addr_o       (cfg_addr_o),
  .cfg_data_o       (cfg_data_o),
  .busy_o           (busy_o),
  .ready_o          (ready_o),
  .done_o           (done_o),
  .timeout_o        (timeout_o)
);

// File: tb/sim_phy_pwrseq.sv
module sim_phy_pwrseq;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1;
  localparam int SET_US = 3;
  localparam int POLL_US = 4;
  localparam int TO_US = 20;
  localparam int S = MHZ * SET_US;
  localparam int P = MHZ * POLL_US;
  localparam int M = (TO_US + POLL_US - 1) / POLL_US;
  localparam int ORG = 3 + 2 * S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, disable_i = 1'b0, lane_ack_i = 1'b1, cfg_ready_i = 1'b0;
  logic phy_rst_o, phy_rst_ovrd_o, lane_rst_n_o, lane_rst_ovrd_o;
  logic ana_pwr_en_o, pcs_pwr_stable_o, pma_pwr_stable_o, test_pd_o, sris_rx_en_o;
  logic cfg_valid_o, busy_o, ready_o, done_o, timeout_o;
  logic [15:0] cfg_addr_o, cfg_data_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  phy_pwrseq #(
    .CLK_MHZ(MHZ), .SETTLE_US(SET_US), .POLL_US(POLL_US), .TIMEOUT_US(TO_US)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .disable_i(disable_i),
    .lane_ack_i(lane_ack_i), .phy_rst_o(phy_rst_o), .phy_rst_ovrd_o(phy_rst_ovrd_o),
    .lane_rst_n_o(lane_rst_n_o), .lane_rst_ovrd_o(lane_rst_ovrd_o),
    .ana_pwr_en_o(ana_pwr_en_o), .pcs_pwr_stable_o(pcs_pwr_stable_o),
    .pma_pwr_stable_o(pma_pwr_stable_o), .test_pd_o(test_pd_o),
    .sris_rx_en_o(sris_rx_en_o), .cfg_valid_o(cfg_valid_o), .cfg_ready_i(cfg_ready_i),
    .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o), .busy_o(busy_o),
    .ready_o(ready_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // One power-up run; ack visible low from edge a onward, ready d edges after valid.
  task automatic run_seq(input int off, input int d, input bit poke);
    int e0, a, c, sp, k, exp_cfg, exp_to;
    int f_tpd, f_prel, f_lrel, f_sris, f_val, f_rdy, f_to, f_done, vcount;
    f_tpd = -1; f_prel = -1; f_lrel = -1; f_sris = -1; f_val = -1;
    f_rdy = -1; f_to = -1; f_done = -1; vcount = 0;
    @(negedge clk);
    lane_ack_i = 1'b1;
    start_i = 1'b1;
    e0 = cyc + 1;
    a = e0 + off;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 200; n++) begin
      c = cyc;
      if (c == e0) begin
        chk(phy_rst_o && !lane_rst_n_o && test_pd_o && busy_o && !sris_rx_en_o,
            "R2 resets asserted", {phy_rst_o, lane_rst_n_o, test_pd_o, busy_o}, 4'b1011);
        chk(phy_rst_ovrd_o && lane_rst_ovrd_o, "R11 overrides set", {phy_rst_ovrd_o, lane_rst_ovrd_o}, 3);
      end
      if (c == e0 + 1)
        chk(ana_pwr_en_o && pcs_pwr_stable_o && pma_pwr_stable_o, "R2 power flags",
            {ana_pwr_en_o, pcs_pwr_stable_o, pma_pwr_stable_o}, 7);
      if (f_tpd < 0 && !test_pd_o) f_tpd = c;
      if (f_prel < 0 && !phy_rst_o) f_prel = c;
      if (f_lrel < 0 && lane_rst_n_o) f_lrel = c;
      if (f_sris < 0 && sris_rx_en_o) f_sris = c;
      if (cfg_valid_o) begin
        if (f_val < 0) begin
          f_val = c;
          chk_eq("R8 cfg address", int'(cfg_addr_o), 'h22);
          chk_eq("R8 cfg data", int'(cfg_data_o), 'h00F5);
        end
        vcount++;
      end
      if (f_done < 0 && done_o) f_done = c;
      if (ready_o) f_rdy = c;
      if (timeout_o) f_to = c;
      if (ready_o || timeout_o) break;
      lane_ack_i = (c + 1 < a);
      cfg_ready_i = (f_val >= 0) && (c + 1 >= f_val + d);
      start_i = poke && (c + 1 == e0 + 4);
      disable_i = poke && (c + 1 == e0 + 4);
      @(negedge clk);
    end
    cfg_ready_i = 1'b0;
    start_i = 1'b0;
    disable_i = 1'b0;
    sp = e0 + ORG;
    if (a <= sp + P) k = 1;
    else k = (a - sp + P - 1) / P;
    chk_eq("R3 test power-down release edge", f_tpd, e0 + 1 + S);
    chk_eq("R4 phy reset release edge", f_prel, e0 + 1 + 2 * S);
    chk_eq("R4 lane reset release edge", f_lrel, e0 + 2 + 2 * S);
    chk_eq("R5 receive mode enable edge", f_sris, sp);
    if (k <= M) begin
      exp_cfg = sp + k * P;
      chk_eq("R6 cfg valid edge", f_val, exp_cfg);
      chk_eq("R8 valid held cycles", vcount, d);
      chk_eq("R8 ready edge", f_rdy, exp_cfg + d);
      chk_eq("R8 done pulse edge", f_done, exp_cfg + d);
      chk_eq("R7 no timeout on success", f_to, -1);
    end else begin
      exp_to = sp + M * P;
      chk_eq("R7 timeout edge", f_to, exp_to);
      chk_eq("R7 done pulse edge", f_done, exp_to);
      chk_eq("R7 no cfg write", f_val, -1);
      chk_eq("R7 ready stays low", f_rdy, -1);
    end
    if (poke) chk_eq("R10 mid-sequence requests ignored", f_tpd, e0 + 1 + S);
  endtask

  task automatic do_disable(input bit both);
    int d0, c, f_lane, f_phy, f_tpd, f_done;
    int busy_at0, busy_at1, busy_at3;
    f_lane = -1; f_phy = -1; f_tpd = -1; f_done = -1;
    busy_at0 = 0; busy_at1 = 0; busy_at3 = 1;
    @(negedge clk);
    disable_i = 1'b1;
    start_i = both;
    d0 = cyc + 1;
    @(negedge clk);
    disable_i = 1'b0;
    start_i = 1'b0;
    for (int n = 0; n < 5; n++) begin
      c = cyc;
      if (f_lane < 0 && !lane_rst_n_o) f_lane = c;
      if (f_phy < 0 && phy_rst_o) f_phy = c;
      if (f_tpd < 0 && test_pd_o) f_tpd = c;
      if (f_done < 0 && done_o) f_done = c;
      if (c == d0) busy_at0 = busy_o;
      if (c == d0 + 1) busy_at1 = busy_o;
      if (c == d0 + 3) busy_at3 = busy_o;
      @(negedge clk);
    end
    if (both) begin
      chk_eq("R10 disable wins over start busy", busy_at0 + busy_at1, 2);
      chk_eq("R10 disable wins over start done", f_done, d0 + 2);
      chk_eq("R10 no power-up after both", busy_at3, 0);
    end else begin
      chk_eq("R9 lane reset edge", f_lane, d0);
      chk_eq("R9 phy reset edge", f_phy, d0 + 1);
      chk_eq("R9 test power-down edge", f_tpd, d0 + 2);
      chk_eq("R9 done edge", f_done, d0 + 2);
      chk_eq("R9 idle after shutdown", busy_at3, 0);
      chk(!ready_o && !timeout_o, "R9 flags cleared", {ready_o, timeout_o}, 0);
      chk(phy_rst_ovrd_o && lane_rst_ovrd_o, "R11 overrides persist",
          {phy_rst_ovrd_o, lane_rst_ovrd_o}, 3);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(phy_rst_o && !lane_rst_n_o && test_pd_o && !phy_rst_ovrd_o && !lane_rst_ovrd_o &&
        !ana_pwr_en_o && !pcs_pwr_stable_o && !pma_pwr_stable_o && !sris_rx_en_o &&
        !cfg_valid_o && cfg_addr_o == 0 && cfg_data_o == 0 && !busy_o && !ready_o &&
        !done_o && !timeout_o, req, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 state during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 state after reset");
    for (int off = ORG - 2; off <= ORG + M * P + 2; off++) begin
      run_seq(off, 1 + (off % 3), (off % 4) == 0);
      do_disable(1'b0);
    end
    run_seq(ORG + M * P + 5, 1, 1'b0);
    run_seq(ORG + 2, 2, 1'b0);
    do_disable(1'b0);
    do_disable(1'b1);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule